// File: doc/BRIEF.md
# Host-to-DSP Transmit Channel with Status

This block carries one data word from a byte-wide host bus to a word-wide DSP bus. The host loads the word one byte at a time into three holding registers. The high and middle bytes may be written in any order. Writing the low byte commits the word. On the next clock, if the DSP-side receive register is empty, the word moves into it and the receive-full flag is raised. The DSP clears that flag by reading the word. While the receive register is still full, a committed word stays in the holding registers and moves across one cycle after the DSP read.

The host sees an 8-bit status value with these fields:
- a transmit-empty flag, which is also routed to a request pin when the host enables requests;
- a derived ready flag, which shows that a write will pass straight through to the DSP side;
- two flags that the DSP sets through its control register.

The block supports an initialize strobe that marks the holding registers empty. Several reset sources return the transfer path to its idle, ready state.

Top module: `hti_tx_chan`

## Requirements
- R1: After hardware reset (rst_n low) the status reads 0x06, rdf_o is 0 and both DSP flags are 0.
- R2: A host write to address 0 (low byte) clears transmit-empty (status bit 1) at the next clock. Writes to address 1 (middle byte) or address 2 (high byte) change no status bit.
- R3: If transmit-empty is 0 and rdf_o is 0, the next clock copies {byte2, byte1, byte0} to dsp_rdata, sets rdf_o and sets transmit-empty.
- R4: Status bit 2 (transmitter ready) is 1 exactly when transmit-empty is 1 and rdf_o is 0.
- R5: While rdf_o is 1, a committed word stays pending and dsp_rdata holds its old value. A dsp_rd pulse clears rdf_o at the next clock, and the pending word transfers on the clock after that.
- R6: hreq_o equals transmit-empty when treq_en is 1, and is 0 when treq_en is 0.
- R7: A host_init pulse sets transmit-empty at the next clock and discards the pending word, so that word never reaches dsp_rdata.
- R8: A pulse on sw_rst, ind_rst or stop_mode sets transmit-empty and transmitter-ready at the next clock and clears rdf_o.
- R9: Status bits 3 and 4 follow dsp_ctl_hf[0] and dsp_ctl_hf[1] after a dsp_ctl_wr. Hardware reset and sw_rst clear them. ind_rst and stop_mode leave them unchanged.
- R10: Status bits 0, 5, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| h_wr | input | 1 | Host byte write strobe |
| h_addr | input | 2 | Byte select: 0 low, 1 middle, 2 high |
| h_wdata | input | 8 | Host write byte |
| host_init | input | 1 | Initialize pulse: mark holding registers empty |
| treq_en | input | 1 | Enables the request output |
| sw_rst | input | 1 | Software reset |
| ind_rst | input | 1 | Individual reset |
| stop_mode | input | 1 | Stop-mode indication |
| stat_o | output | 8 | Host-readable status |
| hreq_o | output | 1 | Host request |
| dsp_rd | input | 1 | DSP read of the receive register |
| dsp_rdata | output | 24 | DSP receive register |
| rdf_o | output | 1 | Receive data full |
| dsp_ctl_wr | input | 1 | DSP control register write |
| dsp_ctl_hf | input | 2 | Host flag values written by the DSP |

## Verification
A transfer state that is held wrongly shows up at once, on the first clock where the bench looks at the result.
- A lost low-byte write leaves transmit-empty high one cycle after that write.
- A missed hand-off leaves rdf_o low two cycles after the low-byte write.
- A word that crosses too early under back-pressure changes dsp_rdata while rdf_o is still high.
- A flag that survives an initialize strobe appears one cycle after the DSP read, as a second transfer that should not happen.
- A reset that clears the wrong flags shows in bits 3 and 4 on the cycle after the reset pulse.

// File: rtl/hti_pkg.sv
package hti_pkg;
    localparam int STAT_W    = 8;
    localparam int BIT_TXDE  = 1;
    localparam int BIT_TRDY  = 2;
    localparam int BIT_FLAG0 = 3;
    localparam int BIT_FLAG1 = 4;

    typedef struct packed {
        logic txde;
        logic rdf;
    } xfer_st_t;
endpackage

// File: rtl/hti_tx_bytes.sv
module hti_tx_bytes #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3,
    parameter int ADDR_W = 2,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] word,
    output logic              lo_wr
);
    assign lo_wr = wr && (addr == '0);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_d, byte_q;
        always_comb begin
            byte_d = byte_q;
            if (wr && (addr == ADDR_W'(g)))
                byte_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end
        assign word[g*BYTE_W +: BYTE_W] = byte_q;
    end
endmodule

// File: rtl/hti_xfer_ctrl.sv
module hti_xfer_ctrl
    import hti_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic              init,
    input  logic              soft_set,
    input  logic              dsp_rd,
    input  logic [WORD_W-1:0] tx_word,
    output logic              txde,
    output logic              rdf,
    output logic [WORD_W-1:0] rx_word
);
    xfer_st_t          st_d, st_q;
    logic [WORD_W-1:0] rx_d, rx_q;
    logic              xfer;

    always_comb begin
        st_d = st_q;
        rx_d = rx_q;
        xfer = !st_q.txde && !st_q.rdf;
        if (dsp_rd && st_q.rdf)
            st_d.rdf = 1'b0;
        if (xfer) begin
            rx_d      = tx_word;
            st_d.rdf  = 1'b1;
            st_d.txde = 1'b1;
        end
        if (lo_wr)
            st_d.txde = 1'b0;
        if (init)
            st_d.txde = 1'b1;
        if (soft_set) begin
            st_d.txde = 1'b1;
            st_d.rdf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{txde: 1'b1, rdf: 1'b0};
            rx_q <= '0;
        end else begin
            st_q <= st_d;
            rx_q <= rx_d;
        end
    end

    assign txde    = st_q.txde;
    assign rdf     = st_q.rdf;
    assign rx_word = rx_q;
endmodule

// File: rtl/hti_flags.sv
module hti_flags #(
    parameter int NFLAGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [NFLAGS-1:0] wdata,
    output logic [NFLAGS-1:0] flags
);
    logic [NFLAGS-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr)  flags_d = wdata;
        if (clr) flags_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/hti_tx_chan.sv
module hti_tx_chan
    import hti_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3,
    parameter int ADDR_W = 2,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [BYTE_W-1:0] h_wdata,
    input  logic              host_init,
    input  logic              treq_en,
    input  logic              sw_rst,
    input  logic              ind_rst,
    input  logic              stop_mode,
    output logic [STAT_W-1:0] stat_o,
    output logic              hreq_o,
    input  logic              dsp_rd,
    output logic [WORD_W-1:0] dsp_rdata,
    output logic              rdf_o,
    input  logic              dsp_ctl_wr,
    input  logic [1:0]        dsp_ctl_hf
);
    logic [WORD_W-1:0] tx_word;
    logic              lo_wr, txde, rdf;
    logic [1:0]        hf;

    hti_tx_bytes #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_bytes (
        .clk(clk), .rst_n(rst_n), .wr(h_wr), .addr(h_addr), .wdata(h_wdata),
        .word(tx_word), .lo_wr(lo_wr)
    );

    hti_xfer_ctrl #(.WORD_W(WORD_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .init(host_init),
        .soft_set(sw_rst || ind_rst || stop_mode), .dsp_rd(dsp_rd),
        .tx_word(tx_word), .txde(txde), .rdf(rdf), .rx_word(dsp_rdata)
    );

    hti_flags #(.NFLAGS(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(sw_rst), .wr(dsp_ctl_wr),
        .wdata(dsp_ctl_hf), .flags(hf)
    );

    always_comb begin
        stat_o            = '0;
        stat_o[BIT_TXDE]  = txde;
        stat_o[BIT_TRDY]  = txde && !rdf;
        stat_o[BIT_FLAG0] = hf[0];
        stat_o[BIT_FLAG1] = hf[1];
    end

    assign hreq_o = txde && treq_en;
    assign rdf_o  = rdf;
endmodule

// File: rtl/hti_tx_chan_chk.sv
module hti_tx_chan_chk #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3,
    parameter int ADDR_W = 2,
    localparam int WORD_W = BYTE_W * NBYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_wr,
    input logic [ADDR_W-1:0] h_addr,
    input logic [BYTE_W-1:0] h_wdata,
    input logic              host_init,
    input logic              treq_en,
    input logic              sw_rst,
    input logic              ind_rst,
    input logic              stop_mode,
    input logic [7:0]        stat_o,
    input logic              hreq_o,
    input logic              dsp_rd,
    input logic [WORD_W-1:0] dsp_rdata,
    input logic              rdf_o,
    input logic              dsp_ctl_wr,
    input logic [1:0]        dsp_ctl_hf
);
    logic quiet;
    assign quiet = !host_init && !sw_rst && !ind_rst && !stop_mode;

    a_r2_low_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == '0 && quiet) |=> !stat_o[1]);

    a_r3_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[1] && !rdf_o && quiet && !(h_wr && h_addr == '0)) |=> (stat_o[1] && rdf_o));

    a_r4_not_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rdf_o |-> !stat_o[2]);

    a_r5_hold_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rdf_o && !dsp_rd && quiet) |=> ($stable(dsp_rdata) && rdf_o));

    a_r6_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !treq_en |-> !hreq_o);

    a_r8_resets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst || ind_rst || stop_mode) |=> (stat_o[1] && stat_o[2] && !rdf_o));

    a_r9_sw_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (stat_o[4:3] == 2'b00));

    always_comb begin
        if (rst_n) a_r10_reserved_zero: assert (stat_o[0] == 1'b0 && stat_o[7:5] == 3'b000);
    end
endmodule

bind hti_tx_chan hti_tx_chan_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/hti_tx_chan_tb_top.sv
module hti_tx_chan_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 1'b0;
    logic [1:0]  h_addr = '0;
    logic [7:0]  h_wdata = '0;
    logic        host_init = 1'b0, treq_en = 1'b0;
    logic        sw_rst = 1'b0, ind_rst = 1'b0, stop_mode = 1'b0;
    logic [7:0]  stat_o;
    logic        hreq_o;
    logic        dsp_rd = 1'b0;
    logic [23:0] dsp_rdata;
    logic        rdf_o;
    logic        dsp_ctl_wr = 1'b0;
    logic [1:0]  dsp_ctl_hf = '0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hti_tx_chan dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(logic [1:0] a, logic [7:0] d);
        h_wr = 1'b1; h_addr = a; h_wdata = d;
        tick();
        h_wr = 1'b0;
    endtask

    task automatic dsp_read();
        dsp_rd = 1'b1;
        tick();
        dsp_rd = 1'b0;
    endtask

    task automatic send_word(logic [23:0] w);
        host_wr(2'd2, w[23:16]);
        host_wr(2'd1, w[15:8]);
        host_wr(2'd0, w[7:0]);
    endtask

    task automatic t_reset();
        check("R1 status", stat_o, 32'h06);
        check("R1 rdf", rdf_o, 0);
        check("R6 hreq off", hreq_o, 0);
        check("R10 reserved", {stat_o[7:5], stat_o[0]}, 0);
    endtask

    task automatic t_basic();
        host_wr(2'd2, 8'hA1);
        check("R2 high byte no effect", stat_o, 32'h06);
        host_wr(2'd1, 8'hB2);
        check("R2 mid byte no effect", stat_o, 32'h06);
        host_wr(2'd0, 8'hC3);
        check("R2 low clears txde", stat_o, 32'h00);
        tick();
        check("R3 rdf set", rdf_o, 1);
        check("R3 data", dsp_rdata, 32'hA1B2C3);
        check("R4 full not ready", stat_o, 32'h02);
    endtask

    task automatic t_backpressure();
        send_word(24'h123456);
        tick(3);
        check("R5 pending", stat_o, 32'h00);
        check("R5 old data", dsp_rdata, 32'hA1B2C3);
        dsp_read();
        check("R5 rdf cleared", rdf_o, 0);
        check("R5 not yet moved", dsp_rdata, 32'hA1B2C3);
        tick();
        check("R5 moved", dsp_rdata, 32'h123456);
        check("R5 rdf again", rdf_o, 1);
        dsp_read();
        check("R4 ready", stat_o, 32'h06);
    endtask

    task automatic t_hreq();
        treq_en = 1'b1;
        tick();
        check("R6 hreq on", hreq_o, 1);
        send_word(24'h0F0F0F);
        check("R6 hreq drops", hreq_o, 0);
        tick();
        check("R6 hreq back", hreq_o, 1);
        treq_en = 1'b0;
        tick();
        check("R6 hreq masked", hreq_o, 0);
        check("R6 txde polled", stat_o[1], 1);
        dsp_read();
    endtask

    task automatic t_init();
        send_word(24'h445566);
        tick();
        send_word(24'h778899);
        check("R7 pending", stat_o[1], 0);
        host_init = 1'b1;
        tick();
        host_init = 1'b0;
        check("R7 txde forced", stat_o[1], 1);
        dsp_read();
        tick();
        check("R7 no transfer", rdf_o, 0);
        check("R7 word discarded", dsp_rdata, 32'h445566);
    endtask

    task automatic t_flags();
        dsp_ctl_wr = 1'b1; dsp_ctl_hf = 2'b01;
        tick();
        check("R9 flag0", stat_o, 32'h0E);
        dsp_ctl_hf = 2'b10;
        tick();
        dsp_ctl_wr = 1'b0;
        check("R9 flag1", stat_o, 32'h16);
    endtask

    task automatic t_one_reset(int which);
        dsp_ctl_wr = 1'b1; dsp_ctl_hf = 2'b11;
        tick();
        dsp_ctl_wr = 1'b0;
        send_word(24'h010203);
        tick();
        send_word(24'h040506);
        check("R8 setup", stat_o, 32'h18);
        case (which)
            0: sw_rst = 1'b1;
            1: ind_rst = 1'b1;
            default: stop_mode = 1'b1;
        endcase
        tick();
        sw_rst = 1'b0; ind_rst = 1'b0; stop_mode = 1'b0;
        check("R8 txde trdy set", stat_o[2:1], 2'b11);
        check("R8 rdf cleared", rdf_o, 0);
        check("R9 flags after reset", stat_o[4:3], (which == 0) ? 2'b00 : 2'b11);
    endtask

    task automatic t_hw_reset();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 hw reset status", stat_o, 32'h06);
        check("R9 hw reset flags", stat_o[4:3], 0);
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_backpressure();
        t_hreq();
        t_init();
        t_flags();
        for (int k = 0; k < 3; k++) t_one_reset(k);
        t_hw_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule